// File: doc/BRIEF.md
# Synchronous master serial receiver

This block is the receive side of a half-duplex synchronous serial link in which it acts as clock master. It divides the system clock by a programmable amount to make a shift clock, drives that clock out only while it wants data, and samples the serial data input on each falling shift-clock edge. Bits are collected least significant first into 8-bit or 9-bit characters.

Software starts reception in one of two ways. A one-cycle request receives exactly one character. A level enable receives characters back to back for as long as it stays high. Finished characters go into a two-entry buffer. A ready flag, a maskable interrupt, the ninth bit and a sticky overrun error report on that buffer. Dropping the port enable puts the whole receiver back to its reset state.

Top module: `sync_rx_master`

## Requirements
- R1: The shift clock half-period is N+1 system clocks. N is `{div_hi, div_lo}` when `div_wide` is 1, and `div_lo` alone when `div_wide` is 0.
- R2: `sclk` is low whenever no reception runs. After a single request, the first rising edge of `sclk` follows N+1 system clocks after the request is registered.
- R3: On each falling edge of `sclk`, `sdata` is stored into the next bit position, starting at bit 0 (least significant bit first).
- R4: A `single_req` pulse sets `single_active`. Exactly one character is then received, and `single_active` clears when that character completes.
- R5: While `cont_en` is high, characters are received back to back. If `cont_en` and `single_active` are both high, reception keeps going after the first character.
- R6: With `nine_bit` = 1 a character has 9 bits, and bit 8 appears on `rx_ninth`. `rx_data` carries bits 7..0 only. With `nine_bit` = 0, `rx_ninth` reads 0.
- R7: The buffer holds up to two characters, oldest first at `rx_data`/`rx_ninth`. A `rd_pop` pulse removes the oldest character. `rx_done` stays high while any character is held.
- R8: `irq` is high exactly when `rx_done` and `irq_en` are both high.
- R9: If a character completes while two characters are held and no pop occurs in that cycle, `ovr_err` sets and the character is discarded. While `ovr_err` is high, `sclk` stays low and nothing more is received.
- R10: `ovr_err` stays set while `cont_en` stays high. A high-to-low change of `cont_en` clears it on the following clock.
- R11: `port_en` low clears the buffer, `ovr_err`, `single_active` and any partial character, and holds `sclk` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Port enable; low resets the receiver |
| div_wide | input | 1 | 1 selects the 16-bit divisor, 0 the low byte only |
| div_hi | input | 8 | Divisor high byte |
| div_lo | input | 8 | Divisor low byte |
| nine_bit | input | 1 | 9-bit character mode |
| single_req | input | 1 | One-cycle request for one character |
| cont_en | input | 1 | Continuous receive enable |
| irq_en | input | 1 | Interrupt mask |
| rd_pop | input | 1 | Removes the oldest buffered character |
| sdata | input | 1 | Serial data from the slave |
| sclk | output | 1 | Generated shift clock |
| rx_data | output | 8 | Oldest character, bits 7..0 |
| rx_ninth | output | 1 | Oldest character, ninth bit |
| rx_done | output | 1 | At least one character is buffered |
| ovr_err | output | 1 | Sticky overrun error |
| irq | output | 1 | Receive interrupt |
| single_active | output | 1 | Single-character reception pending |

## Verification
The bench builds the block with its default 8-bit data width, so the character is 8 or 9 bits. The wide divisor path is reached through a run with a high byte of 1. Small low-byte divisors from 0 to 3 keep each random character to a few dozen cycles. That leaves enough cycles to cover single and continuous modes, both overrun clearing paths, and an abort in the middle of a character within the run.

// File: rtl/sync_rx_master.sv
module sync_rx_master #(
  parameter int DW = 8,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          port_en,
  input  logic          div_wide,
  input  logic [BW-1:0] div_hi,
  input  logic [BW-1:0] div_lo,
  input  logic          nine_bit,
  input  logic          single_req,
  input  logic          cont_en,
  input  logic          irq_en,
  input  logic          rd_pop,
  input  logic          sdata,
  output logic          sclk,
  output logic [DW-1:0] rx_data,
  output logic          rx_ninth,
  output logic          rx_done,
  output logic          ovr_err,
  output logic          irq,
  output logic          single_active
);
  localparam int CW   = DW + 1;
  localparam int DIVW = 2 * BW;
  localparam int BCW  = $clog2(CW);

  logic [DIVW-1:0] div_n, div_cnt;
  logic [BCW-1:0]  bit_cnt;
  logic [CW-1:0]   shreg, chr, buf0, buf1;
  logic [1:0]      cnt;
  logic            single_en, ovr, cont_q, sclk_r;

  assign div_n = div_wide ? {div_hi, div_lo} : {{BW{1'b0}}, div_lo};

  wire run  = port_en & ~ovr & (cont_en | single_en);
  wire tick = run & (div_cnt == div_n);
  wire last = (bit_cnt == (nine_bit ? BCW'(DW) : BCW'(DW - 1)));
  wire done = tick & sclk_r & last;
  wire pop  = rd_pop & (cnt != 2'd0);
  wire full = (cnt == 2'd2) & ~pop;
  wire push = done & ~full;
  wire [1:0] slot = cnt - {1'b0, pop};

  always_comb begin
    chr = shreg;
    chr[bit_cnt] = sdata;
    if (!nine_bit) chr[DW] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_r <= 1'b0; div_cnt <= '0; bit_cnt <= '0; shreg <= '0;
      single_en <= 1'b0; ovr <= 1'b0; cont_q <= 1'b0;
      cnt <= 2'd0; buf0 <= '0; buf1 <= '0;
    end else if (!port_en) begin
      sclk_r <= 1'b0; div_cnt <= '0; bit_cnt <= '0;
      single_en <= 1'b0; ovr <= 1'b0; cont_q <= 1'b0;
      cnt <= 2'd0;
    end else begin
      cont_q <= cont_en;
      if (!run) begin
        sclk_r <= 1'b0; div_cnt <= '0; bit_cnt <= '0;
      end else if (tick) begin
        div_cnt <= '0;
        sclk_r  <= ~sclk_r;
        if (sclk_r) begin
          shreg   <= chr;
          bit_cnt <= last ? '0 : bit_cnt + 1'b1;
        end
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end

      if (single_req)  single_en <= 1'b1;
      else if (done)   single_en <= 1'b0;

      if (done && full)            ovr <= 1'b1;
      else if (cont_q && !cont_en) ovr <= 1'b0;

      if (pop) buf0 <= buf1;
      if (push) begin
        if (slot == 2'd0) buf0 <= chr;
        else              buf1 <= chr;
      end
      cnt <= cnt - {1'b0, pop} + {1'b0, push};
    end
  end

  assign sclk          = sclk_r;
  assign rx_data       = buf0[DW-1:0];
  assign rx_ninth      = buf0[DW];
  assign rx_done       = (cnt != 2'd0);
  assign irq           = rx_done & irq_en;
  assign ovr_err       = ovr;
  assign single_active = single_en;
endmodule

// File: rtl/sync_rx_master_chk.sv
module sync_rx_master_chk (
  input logic clk,
  input logic rst_n,
  input logic port_en,
  input logic cont_en,
  input logic rd_pop,
  input logic sclk,
  input logic rx_done,
  input logic ovr_err,
  input logic single_active
);
  p_disable_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> (!sclk && !rx_done && !ovr_err && !single_active));

  p_halt_on_overrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_err |-> !sclk);

  p_overrun_needs_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_err) |-> rx_done);

  p_overrun_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_err && port_en && cont_en) |=> ovr_err);

  p_flag_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !rd_pop && port_en) |=> rx_done);

  p_single_ends_on_char_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(single_active) |-> (rx_done || ovr_err || !$past(port_en)));
endmodule

bind sync_rx_master sync_rx_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .port_en(port_en), .cont_en(cont_en),
  .rd_pop(rd_pop), .sclk(sclk), .rx_done(rx_done), .ovr_err(ovr_err),
  .single_active(single_active)
);

// File: tb/sync_rx_master_tb.sv
`timescale 1ns/1ps
module sync_rx_master_tb;
  logic clk = 1'b0, rst_n = 1'b0, port_en = 1'b0, div_wide = 1'b0;
  logic [7:0] div_hi = 8'd0, div_lo = 8'd0;
  logic nine_bit = 1'b0, single_req = 1'b0, cont_en = 1'b0, irq_en = 1'b0;
  logic rd_pop = 1'b0, sdata = 1'b0;
  logic sclk, rx_done, rx_ninth, ovr_err, irq, single_active;
  logic [7:0] rx_data;

  int errs = 0, checks = 0;
  logic [8:0] words [0:15];
  int ci = 0, bi = 0;

  always #4 clk = ~clk;

  sync_rx_master u_dut (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .div_wide(div_wide),
    .div_hi(div_hi), .div_lo(div_lo), .nine_bit(nine_bit),
    .single_req(single_req), .cont_en(cont_en), .irq_en(irq_en),
    .rd_pop(rd_pop), .sdata(sdata), .sclk(sclk), .rx_data(rx_data),
    .rx_ninth(rx_ninth), .rx_done(rx_done), .ovr_err(ovr_err), .irq(irq),
    .single_active(single_active)
  );

  always @(posedge sclk) begin
    sdata = words[ci[3:0]][bi];
    bi++;
    if (bi == (nine_bit ? 9 : 8)) begin bi = 0; ci++; end
  end

  function automatic int exp_data(input logic [8:0] w);
    return int'(w[7:0]);
  endfunction
  function automatic int exp_ninth(input logic [8:0] w, input logic nb);
    return nb ? int'(w[8]) : 0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic slave_reset();
    ci = 0; bi = 0;
  endtask

  task automatic pulse_pop();
    rd_pop = 1'b1; @(negedge clk); rd_pop = 1'b0;
  endtask

  task automatic pulse_single();
    single_req = 1'b1; @(negedge clk); single_req = 1'b0;
  endtask

  task automatic port_cycle();
    cont_en = 1'b0; port_en = 1'b0;
    @(negedge clk); @(negedge clk);
    port_en = 1'b1; @(negedge clk);
    slave_reset();
  endtask

  task automatic wait_done(input int lim, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < lim; i++) begin
      if (rx_done) begin ok = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic wait_ovr(input int lim, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < lim; i++) begin
      if (ovr_err) begin ok = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic measure(output int period);
    logic prev;
    while (sclk !== 1'b0) @(negedge clk);
    while (sclk !== 1'b1) @(negedge clk);
    period = 0; prev = 1'b1;
    do begin
      prev = sclk; @(negedge clk); period++;
    end while (!(prev == 1'b0 && sclk == 1'b1) && period < 2000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    bit ok;
    int p, n, seen;
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) words[i] = 9'(i * 37 + 5);

    repeat (3) @(negedge clk);
    rst_n = 1'b1; port_en = 1'b1; @(negedge clk);
    chk("R11 reset sclk", sclk, 0);
    chk("R11 reset rx_done", rx_done, 0);
    chk("R11 reset ovr_err", ovr_err, 0);
    chk("R8 reset irq", irq, 0);
    chk("R4 reset single_active", single_active, 0);

    // R1: divider scaling, narrow and wide
    div_lo = 8'd2; div_wide = 1'b0; cont_en = 1'b1;
    measure(p); chk("R1 narrow period", p, 6);
    port_cycle();
    div_hi = 8'd1; div_wide = 1'b1; cont_en = 1'b1;
    measure(p); chk("R1 wide period", p, 2 * (256 + 2 + 1));
    port_cycle();
    div_wide = 1'b0; div_hi = 8'd0;

    // R2: first rise after a single request
    div_lo = 8'd3; nine_bit = 1'b0; words[0] = 9'h0A5;
    single_req = 1'b1; n = 0;
    @(negedge clk); single_req = 1'b0; n = 1;
    while (sclk !== 1'b1 && n < 100) begin @(negedge clk); n++; end
    chk("R2 first rise delay", n, 3 + 2);
    wait_done(500, ok);
    chk("R4 single done", ok, 1);
    chk("R3 data lsb first", rx_data, exp_data(words[0]));
    pulse_pop();

    // R3 R4 R6: random single characters
    for (int k = 0; k < 16; k++) begin
      logic [8:0] w;
      slave_reset();
      div_lo = 8'($urandom % 4);
      nine_bit = 1'($urandom % 2);
      w = 9'($urandom % 512);
      words[0] = w; words[1] = ~w;
      pulse_single();
      wait_done(1000, ok);
      chk("R4 single char arrives", ok, 1);
      chk("R3 single data", rx_data, exp_data(w));
      chk("R6 ninth bit", rx_ninth, exp_ninth(w, nine_bit));
      chk("R4 single_active cleared", single_active, 0);
      pulse_pop();
      seen = 0;
      for (int c = 0; c < 40; c++) begin
        if (sclk || rx_done) seen = 1;
        @(negedge clk);
      end
      chk("R4 only one char", seen, 0);
      chk("R2 idle low", sclk, 0);
    end

    // R5: continuous reception, nine-bit
    slave_reset();
    div_lo = 8'd1; nine_bit = 1'b1;
    words[0] = 9'h1C3; words[1] = 9'h03C; words[2] = 9'h155;
    cont_en = 1'b1;
    for (int k = 0; k < 3; k++) begin
      wait_done(500, ok);
      chk("R5 continuous char", ok, 1);
      chk("R5 continuous data", rx_data, exp_data(words[k]));
      chk("R6 continuous ninth", rx_ninth, exp_ninth(words[k], 1'b1));
      pulse_pop();
    end
    port_cycle();

    // R5: continuous takes precedence over single
    nine_bit = 1'b0; div_lo = 8'd0;
    words[0] = 9'h011; words[1] = 9'h0EE;
    cont_en = 1'b1; pulse_single();
    wait_done(500, ok);
    chk("R5 precedence first", rx_data, exp_data(words[0]));
    pulse_pop();
    wait_done(500, ok);
    chk("R5 precedence second arrives", ok, 1);
    chk("R5 precedence second data", rx_data, exp_data(words[1]));
    chk("R4 single cleared under cont", single_active, 0);
    port_cycle();

    // R7 R8: two-entry buffer and interrupt mask
    words[0] = 9'h06B; words[1] = 9'h0D2;
    pulse_single();
    wait_done(500, ok);
    irq_en = 1'b0; @(negedge clk);
    chk("R8 irq masked", irq, 0);
    irq_en = 1'b1; @(negedge clk);
    chk("R8 irq on", irq, 1);
    pulse_single();
    n = 0;
    while (single_active && n < 500) begin @(negedge clk); n++; end
    chk("R7 head is oldest", rx_data, exp_data(words[0]));
    pulse_pop();
    chk("R7 still done after one pop", rx_done, 1);
    chk("R7 second entry", rx_data, exp_data(words[1]));
    pulse_pop();
    chk("R7 empty after two pops", rx_done, 0);
    chk("R8 irq off when empty", irq, 0);
    irq_en = 1'b0;

    // R9 R10: overrun, cleared by dropping cont_en
    slave_reset();
    words[0] = 9'h0A1; words[1] = 9'h0B2; words[2] = 9'h0C3;
    cont_en = 1'b1;
    wait_ovr(2000, ok);
    chk("R9 overrun raised", ok, 1);
    seen = 0;
    for (int c = 0; c < 20; c++) begin
      if (sclk) seen = 1;
      @(negedge clk);
    end
    chk("R9 clock halted", seen, 0);
    chk("R9 first kept", rx_data, exp_data(words[0]));
    pulse_pop();
    chk("R9 second kept", rx_data, exp_data(words[1]));
    pulse_pop();
    chk("R9 third discarded", rx_done, 0);
    repeat (10) @(negedge clk);
    chk("R10 sticky with cont high", ovr_err, 1);
    chk("R9 no reception during error", rx_done, 0);
    cont_en = 1'b0; @(negedge clk);
    chk("R10 cleared by cont drop", ovr_err, 0);

    // R11: overrun cleared by port enable
    slave_reset();
    cont_en = 1'b1;
    wait_ovr(2000, ok);
    chk("R9 overrun again", ok, 1);
    port_en = 1'b0; @(negedge clk);
    chk("R11 ovr cleared by port_en", ovr_err, 0);
    chk("R11 buffer cleared", rx_done, 0);
    port_en = 1'b1; cont_en = 1'b0; @(negedge clk);
    slave_reset();

    // R11: abort in the middle of a character
    div_lo = 8'd2; cont_en = 1'b1;
    while (sclk !== 1'b1) @(negedge clk);
    port_en = 1'b0; @(negedge clk);
    chk("R11 sclk low on abort", sclk, 0);
    chk("R11 no char on abort", rx_done, 0);
    port_en = 1'b1; cont_en = 1'b0; @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule